// File: doc/BRIEF.md
# Quad-Channel Pulse-Width Modulator

This block drives four independent pulse-width modulated outputs from one simple memory-mapped register bus. The bus has a byte address, 32-bit write data, a write strobe and a combinational read-data return. Each channel holds three configuration values and a run bit. The first value is a clock divider: the channel's step counter advances once every divider+1 input clocks. The second is the period length in steps. The third is the number of steps at the start of each period during which the output is high.

Configuration values are staged. Writing the divider or the period length alone changes nothing that is running. A write to the duty value arms a commit. The counter picks up all three staged values together when the period in progress completes, so no period mixes old and new settings. Clearing the run bit stops the channel in the next cycle. Setting it on a stopped channel loads the staged values at once and starts a fresh period. A driver therefore programs divider, then period, then duty, and then sets the run bit.

Top module: `pwm_quad`

## Requirements
- R1: After reset every output is low and every mapped register reads zero.
- R2: A channel's registers sit at byte address channel*32 + offset, with the divider in bits 7:0 at offset 0x00, the period length in bits 7:0 at 0x04, the duty in bits 15:0 at 0x08 and the run bit in bit 0 at 0x18. A read returns the last value written, truncated to the field and zero-extended to 32 bits.
- R3: Addresses with any other offset, or with a channel index of four or more, read as zero, and writes to them change no register and no output.
- R4: A running channel with divider P, period M and duty D (0 < D < M) repeats a period of (P+1)*M clocks, high for the first (P+1)*D clocks and low for the rest.
- R5: A duty of zero keeps the running output constantly low, and a duty of at least the period length keeps it constantly high.
- R6: Setting the run bit of a stopped channel loads the staged values at once and begins a period, so the output of the clock after the write is the first clock of that period.
- R7: Writes to the divider or period length alone do not alter a running channel. The next duty write commits all three staged values.
- R8: A commit that arrives during a period takes effect at the first clock after that period ends, and the remainder of the current period keeps the old settings.
- R9: Clearing the run bit forces the output low from the clock after the write, regardless of period position.
- R10: Each channel's output depends only on its own registers. Stopped channels stay low while others run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (8) | Byte address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pwm_out | output | NUM_CH (4) | One modulated output per channel |

## Verification
The checker assumes that at most one register write arrives per clock, that the bus is the only path into the registers, and that read data is taken combinationally from the current address. The step-bound property presumes a nonzero committed period length. The stimulus therefore programs only nonzero period lengths and never moves more than one register per cycle. Commit writes are placed away from the period-end edge, so the expected timing of each boundary follows from the requirements alone. Input changes happen one time unit after a rising edge, and the output is sampled at the falling edge.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    localparam int DATA_W     = 32;
    localparam int PRE_W      = 8;
    localparam int MOD_W      = 8;
    localparam int DUTY_W     = 16;
    localparam int BANK_SHIFT = 5;

    localparam logic [BANK_SHIFT-1:0] OFS_PRE  = 5'h00;
    localparam logic [BANK_SHIFT-1:0] OFS_MOD  = 5'h04;
    localparam logic [BANK_SHIFT-1:0] OFS_DUTY = 5'h08;
    localparam logic [BANK_SHIFT-1:0] OFS_RUN  = 5'h18;

    typedef struct packed {
        logic [PRE_W-1:0]  pre;
        logic [MOD_W-1:0]  mod;
        logic [DUTY_W-1:0] duty;
    } pwm_cfg_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_PRE,
        SEL_MOD,
        SEL_DUTY,
        SEL_RUN
    } reg_sel_e;

    function automatic reg_sel_e decode_ofs(input logic [BANK_SHIFT-1:0] ofs);
        reg_sel_e s;
        case (ofs)
            OFS_PRE:  s = SEL_PRE;
            OFS_MOD:  s = SEL_MOD;
            OFS_DUTY: s = SEL_DUTY;
            OFS_RUN:  s = SEL_RUN;
            default:  s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/pwm_bank_regs.sv
module pwm_bank_regs
    import pwm_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [DATA_W-1:0]       wdata,
    input  logic                    we,
    output logic [DATA_W-1:0]       rdata,
    output pwm_cfg_t [NUM_CH-1:0]   stage_cfg_o,
    output logic [NUM_CH-1:0]       start_o,
    output logic [NUM_CH-1:0]       stop_o,
    output logic [NUM_CH-1:0]       commit_o
);

    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    logic [ADDR_W-1:0] bank_idx;
    logic              bank_hit;
    logic [CH_W-1:0]   ch_sel;
    reg_sel_e          sel;
    logic [DATA_W-1:0] rd_bus [NUM_CH];

    assign bank_idx = addr >> BANK_SHIFT;
    assign bank_hit = bank_idx < ADDR_W'(NUM_CH);
    assign ch_sel   = bank_idx[CH_W-1:0];
    assign sel      = bank_hit ? decode_ofs(addr[BANK_SHIFT-1:0]) : SEL_NONE;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_bank
        pwm_cfg_t          cfg_q;
        logic              run_q;
        logic              wr_here;
        logic [DATA_W-1:0] rd_val;

        assign wr_here = we && bank_hit && (ch_sel == CH_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_q <= '0;
                run_q <= 1'b0;
            end else if (wr_here) begin
                case (sel)
                    SEL_PRE:  cfg_q.pre  <= wdata[PRE_W-1:0];
                    SEL_MOD:  cfg_q.mod  <= wdata[MOD_W-1:0];
                    SEL_DUTY: cfg_q.duty <= wdata[DUTY_W-1:0];
                    SEL_RUN:  run_q      <= wdata[0];
                    default:  ;
                endcase
            end
        end

        always_comb begin
            case (sel)
                SEL_PRE:  rd_val = {{(DATA_W-PRE_W){1'b0}}, cfg_q.pre};
                SEL_MOD:  rd_val = {{(DATA_W-MOD_W){1'b0}}, cfg_q.mod};
                SEL_DUTY: rd_val = {{(DATA_W-DUTY_W){1'b0}}, cfg_q.duty};
                SEL_RUN:  rd_val = {{(DATA_W-1){1'b0}}, run_q};
                default:  rd_val = '0;
            endcase
        end

        assign rd_bus[g]      = rd_val;
        assign stage_cfg_o[g] = cfg_q;
        assign start_o[g]     = wr_here && (sel == SEL_RUN) && wdata[0] && !run_q;
        assign stop_o[g]      = wr_here && (sel == SEL_RUN) && !wdata[0] && run_q;
        assign commit_o[g]    = wr_here && (sel == SEL_DUTY);
    end

    always_comb begin
        rdata = '0;
        if (bank_hit) begin
            rdata = rd_bus[ch_sel];
        end
    end

endmodule

// File: rtl/pwm_chan_core.sv
module pwm_chan_core
    import pwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             commit_i,
    input  pwm_cfg_t         stage_i,
    output logic             pwm_o,
    output logic             run_o,
    output logic [MOD_W-1:0] step_o,
    output pwm_cfg_t         act_o
);

    pwm_cfg_t         act_q;
    logic             run_q;
    logic             pend_q;
    logic [PRE_W-1:0] pre_cnt_q;
    logic [MOD_W-1:0] step_q;

    logic             pre_wrap;
    logic             step_last;
    logic [MOD_W:0]   step_inc;

    assign pre_wrap  = (pre_cnt_q == act_q.pre);
    assign step_inc  = {1'b0, step_q} + (MOD_W+1)'(1);
    assign step_last = (step_inc >= {1'b0, act_q.mod});

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q     <= '0;
            run_q     <= 1'b0;
            pend_q    <= 1'b0;
            pre_cnt_q <= '0;
            step_q    <= '0;
        end else if (stop_i) begin
            run_q     <= 1'b0;
            pend_q    <= 1'b0;
            pre_cnt_q <= '0;
            step_q    <= '0;
        end else if (start_i) begin
            run_q     <= 1'b1;
            pend_q    <= 1'b0;
            act_q     <= stage_i;
            pre_cnt_q <= '0;
            step_q    <= '0;
        end else if (run_q) begin
            if (commit_i) begin
                pend_q <= 1'b1;
            end
            if (pre_wrap) begin
                pre_cnt_q <= '0;
                if (step_last) begin
                    step_q <= '0;
                    if (pend_q) begin
                        act_q  <= stage_i;
                        pend_q <= commit_i;
                    end
                end else begin
                    step_q <= step_inc[MOD_W-1:0];
                end
            end else begin
                pre_cnt_q <= pre_cnt_q + PRE_W'(1);
            end
        end
    end

    assign pwm_o  = run_q && ({{(DUTY_W-MOD_W){1'b0}}, step_q} < act_q.duty);
    assign run_o  = run_q;
    assign step_o = step_q;
    assign act_o  = act_q;

endmodule

// File: rtl/pwm_quad.sv
module pwm_quad
    import pwm_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_we,
    output logic [31:0]       bus_rdata,
    output logic [NUM_CH-1:0] pwm_out
);

    pwm_cfg_t [NUM_CH-1:0]            stage_w;
    pwm_cfg_t [NUM_CH-1:0]            act_w;
    logic [NUM_CH-1:0]                start_w;
    logic [NUM_CH-1:0]                stop_w;
    logic [NUM_CH-1:0]                commit_w;
    logic [NUM_CH-1:0]                run_w;
    logic [NUM_CH-1:0][MOD_W-1:0]     step_w;

    pwm_bank_regs #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W)
    ) regs_i (
        .clk         (clk),
        .rst         (rst),
        .addr        (bus_addr),
        .wdata       (bus_wdata),
        .we          (bus_we),
        .rdata       (bus_rdata),
        .stage_cfg_o (stage_w),
        .start_o     (start_w),
        .stop_o      (stop_w),
        .commit_o    (commit_w)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        pwm_chan_core core_i (
            .clk      (clk),
            .rst      (rst),
            .start_i  (start_w[g]),
            .stop_i   (stop_w[g]),
            .commit_i (commit_w[g]),
            .stage_i  (stage_w[g]),
            .pwm_o    (pwm_out[g]),
            .run_o    (run_w[g]),
            .step_o   (step_w[g]),
            .act_o    (act_w[g])
        );
    end

endmodule

// File: rtl/pwm_quad_chk.sv
module pwm_quad_chk
    import pwm_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8
) (
    input logic                        clk,
    input logic                        rst,
    input logic [ADDR_W-1:0]           bus_addr,
    input logic [31:0]                 bus_wdata,
    input logic                        bus_we,
    input logic [31:0]                 bus_rdata,
    input logic [NUM_CH-1:0]           pwm_out,
    input logic [NUM_CH-1:0]           run_i,
    input logic [NUM_CH-1:0][MOD_W-1:0] step_i,
    input pwm_cfg_t [NUM_CH-1:0]       act_i
);

    logic [ADDR_W-1:0] bank_c;
    logic              hit_c;
    logic              mapped_c;

    assign bank_c   = bus_addr >> BANK_SHIFT;
    assign hit_c    = bank_c < ADDR_W'(NUM_CH);
    assign mapped_c = hit_c && (decode_ofs(bus_addr[BANK_SHIFT-1:0]) != SEL_NONE);

    assert_unmapped_zero_R3: assert property (@(posedge clk) disable iff (rst)
        !mapped_c |-> (bus_rdata == 32'h0));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        logic clr_hit;
        assign clr_hit = bus_we && hit_c && (bank_c == ADDR_W'(i))
                         && (bus_addr[BANK_SHIFT-1:0] == OFS_RUN) && !bus_wdata[0];

        assert_stop_now_R9: assert property (@(posedge clk) disable iff (rst)
            clr_hit |=> !pwm_out[i]);

        assert_step_bound_R4: assert property (@(posedge clk) disable iff (rst)
            (run_i[i] && act_i[i].mod != '0) |-> (step_i[i] < act_i[i].mod));

        assert_commit_edge_R8: assert property (@(posedge clk) disable iff (rst)
            ($past(run_i[i]) && run_i[i] && (act_i[i] != $past(act_i[i])))
            |-> (step_i[i] == '0));

        assert_zero_low_R5: assert property (@(posedge clk) disable iff (rst)
            (act_i[i].duty == '0) |-> !pwm_out[i]);

        assert_full_high_R5: assert property (@(posedge clk) disable iff (rst)
            (run_i[i] && act_i[i].mod != '0
             && act_i[i].duty >= {{(DUTY_W-MOD_W){1'b0}}, act_i[i].mod})
            |-> pwm_out[i]);
    end

endmodule

bind pwm_quad pwm_quad_chk #(
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_rdata (bus_rdata),
    .pwm_out   (pwm_out),
    .run_i     (run_w),
    .step_i    (step_w),
    .act_i     (act_w)
);

// File: tb/pwm_quad_tb_top.sv
`timescale 1ns/1ps
module pwm_quad_tb_top;

    localparam int NUM_CH = 4;
    localparam logic [7:0] O_PRE = 8'h00, O_MOD = 8'h04, O_DUTY = 8'h08, O_RUN = 8'h18;

    // {channel, divider, period, duty}
    localparam logic [39:0] VEC [6] = '{
        40'h00_00_08_0003,
        40'h01_02_05_0002,
        40'h02_01_06_0000,
        40'h03_00_04_0009,
        40'h00_03_0A_000A,
        40'h02_FF_02_0001
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [7:0]        bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic              bus_we = 1'b0;
    logic [31:0]       bus_rdata;
    logic [NUM_CH-1:0] pwm_out;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    pwm_quad #(.NUM_CH(NUM_CH), .ADDR_W(8)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out)
    );

    function automatic logic [7:0] ra(input int ch, input logic [7:0] ofs);
        return 8'(ch * 32) + ofs;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(posedge clk);
        #1;
        bus_we    = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            check(1'b0, "watchdog", 0, 1);
            summary();
        end
    end

    initial begin
        logic [31:0] d;
        int bad, others;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        check(pwm_out == '0, "R1 outputs low", pwm_out, 0);
        bad = 0;
        for (int c = 0; c < NUM_CH; c++) begin
            rd(ra(c, O_PRE), d);  if (d != 0) bad++;
            rd(ra(c, O_MOD), d);  if (d != 0) bad++;
            rd(ra(c, O_DUTY), d); if (d != 0) bad++;
            rd(ra(c, O_RUN), d);  if (d != 0) bad++;
        end
        check(bad == 0, "R1 registers zero", bad, 0);

        // R2: field widths and zero extension
        wr(ra(2, O_PRE), 32'hFFFF_FF5A);
        wr(ra(2, O_MOD), 32'h1234_5678);
        wr(ra(2, O_DUTY), 32'hDEAD_BEEF);
        rd(ra(2, O_PRE), d);  check(d == 32'h5A, "R2 divider readback", d, 32'h5A);
        rd(ra(2, O_MOD), d);  check(d == 32'h78, "R2 period readback", d, 32'h78);
        rd(ra(2, O_DUTY), d); check(d == 32'hBEEF, "R2 duty readback", d, 32'hBEEF);
        wr(ra(2, O_RUN), 32'hFFFF_FFFF);
        rd(ra(2, O_RUN), d);  check(d == 32'h1, "R2 run readback", d, 1);
        wr(ra(2, O_RUN), 32'h0);
        rd(ra(1, O_PRE), d);  check(d == 0, "R2 R10 neighbour bank untouched", d, 0);

        // R3: unmapped offsets and out-of-range banks
        wr(ra(0, O_MOD), 32'h8);
        wr(ra(0, O_DUTY), 32'h5);
        wr(8'h0C, 32'hFFFF_FFFF);
        rd(8'h0C, d); check(d == 0, "R3 hole offset reads zero", d, 0);
        wr(8'h84, 32'h33);
        rd(ra(0, O_MOD), d); check(d == 32'h8, "R3 high bank no alias", d, 8);
        rd(8'h84, d); check(d == 0, "R3 high bank reads zero", d, 0);
        wr(8'h98, 32'h1);
        bad = 0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (pwm_out != '0) bad++;
        end
        check(bad == 0, "R3 write to high bank run offset ignored", bad, 0);
        rd(ra(0, O_RUN), d); check(d == 0, "R3 channel 0 still stopped", d, 0);

        // Table walk: R4, R5, R6, R10
        for (int v = 0; v < 6; v++) begin
            int ch, p, m, dt, per, hi;
            string tag;
            ch = int'(VEC[v][39:32]);
            p  = int'(VEC[v][31:24]);
            m  = int'(VEC[v][23:16]);
            dt = int'(VEC[v][15:0]);
            per = (p + 1) * m;
            hi  = (p + 1) * ((dt < m) ? dt : m);
            tag = (dt == 0 || dt >= m) ? "R5 R6 waveform" : "R4 R6 waveform";
            wr(ra(ch, O_RUN), 32'h0);
            wr(ra(ch, O_PRE), 32'(p));
            wr(ra(ch, O_MOD), 32'(m));
            wr(ra(ch, O_DUTY), 32'(dt));
            wr(ra(ch, O_RUN), 32'h1);
            bad = 0;
            others = 0;
            for (int i = 0; i < 2 * per; i++) begin
                logic e;
                @(negedge clk);
                e = ((i % per) < hi);
                if (pwm_out[ch] !== e) bad++;
                if ((pwm_out & ~(NUM_CH'(1) << ch)) != '0) others++;
            end
            check(bad == 0, tag, bad, 0);
            check(others == 0, "R10 stopped channels low", others, 0);
            wr(ra(ch, O_RUN), 32'h0);
        end

        // R7 R8 R9: staged commit on channel 1
        wr(ra(1, O_RUN), 32'h0);
        wr(ra(1, O_PRE), 32'h0);
        wr(ra(1, O_MOD), 32'h8);
        wr(ra(1, O_DUTY), 32'h2);
        wr(ra(1, O_RUN), 32'h1);
        bad = 0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            if (pwm_out[1] !== (i < 2)) bad++;
        end
        check(bad == 0, "R6 first period start", bad, 0);
        wr(ra(1, O_DUTY), 32'h6);
        bad = 0;
        for (int i = 3; i < 8; i++) begin
            @(negedge clk);
            if (pwm_out[1] !== 1'b0) bad++;
        end
        check(bad == 0, "R8 rest of period keeps old duty", bad, 0);
        bad = 0;
        for (int i = 8; i < 16; i++) begin
            @(negedge clk);
            if (pwm_out[1] !== ((i - 8) < 6)) bad++;
        end
        check(bad == 0, "R8 new duty from next period", bad, 0);
        wr(ra(1, O_MOD), 32'h4);
        bad = 0;
        for (int i = 16; i < 23; i++) begin
            @(negedge clk);
            if (pwm_out[1] !== ((i - 16) < 6)) bad++;
        end
        check(bad == 0, "R7 period write alone has no effect", bad, 0);
        wr(ra(1, O_DUTY), 32'h1);
        @(negedge clk);
        check(pwm_out[1] == 1'b0, "R8 cycle before boundary unchanged", pwm_out[1], 0);
        bad = 0;
        for (int i = 24; i < 32; i++) begin
            @(negedge clk);
            if (pwm_out[1] !== ((i % 4) == 0)) bad++;
        end
        check(bad == 0, "R7 duty write commits period and duty", bad, 0);
        wr(ra(1, O_RUN), 32'h0);
        @(negedge clk);
        check(pwm_out[1] == 1'b0, "R9 stop at period start", pwm_out[1], 0);
        @(negedge clk);
        check(pwm_out == '0, "R9 stays low", pwm_out, 0);

        finished = 1;
        summary();
    end

endmodule